// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Host Controller

This block is the host side of a three-wire serial EEPROM link (chip select, serial clock, host-to-device data, device-to-host data). A client hands it one operation at a time: read a word, write a word, erase a word, enable writes, disable writes, erase the whole array, or fill the whole array with one word. The controller turns that into a framed bit stream and clocks it out. All serial timing is derived from the system clock. It returns read data and flags a device that never finishes a write.

After reset the block holds off all traffic for a programmable power-up interval. Every frame begins with a start bit and a two-bit opcode. The instructions that share the opcode 00 are told apart by the two top address bits. After any instruction that programs the array, the controller raises chip select again and polls the device's data line until it reads ready. If ready does not arrive within a programmable number of cycles, the poll is abandoned and an error is reported.

Top module: `mw_host_ctl`

## Requirements
- R1: After reset, `cmd_ready`, `eep_cs`, `eep_sk`, `eep_mosi`, `rsp_done`, `rsp_err` and `rsp_rdata` are all low, and `cmd_ready` stays low for at least PWRUP_CYC cycles whatever `cmd_valid` does.
- R2: `cmd_op` codes are 0 read, 1 write, 2 erase, 3 write-enable, 4 write-disable, 5 erase-all and 6 write-all. A frame is sent most significant bit first as: a 1, a two-bit opcode, the eight address bits, then the sixteen data bits for write and write-all only. The opcode is 10 for read, 01 for write and 11 for erase.
- R3: Write-enable, write-disable, erase-all and write-all send opcode 00. Their address field carries 11, 00, 10 or 01 respectively in its two top bits and zeros below.
- R4: Each serial clock high phase and each low phase inside a frame lasts HALF_CYC system cycles, where HALF_CYC = ceil(CLK_HZ / (2*SK_HZ)). `eep_mosi` changes only when the serial clock falls, so it is stable at every rising edge. Chip select rises with the serial clock low, one full low phase before the first rising edge.
- R5: A read sends 28 rising edges. `eep_miso` is sampled at the end of each low phase from the 12th slot onward. The first sample (the device's leading zero) is dropped, and the next 16 samples form `rsp_rdata`, most significant bit first, valid with `rsp_done`.
- R6: Chip select stays low for at least HALF_CYC cycles before each rise, between frames and between a frame and its poll.
- R7: After write, erase, erase-all or write-all, chip select is raised again without clocking. `eep_miso` is sampled once per half period: low means busy and high means done. Done ends the poll with `rsp_err` low.
- R8: If ready is not seen within BUSY_TMO_CYC cycles of poll start, chip select drops, and the operation ends with `rsp_done` and `rsp_err` high.
- R9: `rsp_done` is a one-cycle pulse per accepted command. `cmd_ready` is high only while idle, and `cmd_valid` is ignored while `cmd_ready` is low: no frame results.
- R10: Read, write-enable and write-disable end after their frame with no poll (one chip-select pulse per command).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Start the operation on `cmd_op` when `cmd_ready` is high |
| cmd_op | input | 3 | Operation code per R2 (7 is sent as write-disable) |
| cmd_addr | input | ADDR_W | Word address |
| cmd_wdata | input | DATA_W | Data for write and write-all |
| cmd_ready | output | 1 | Idle and accepting a command |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Busy-poll timeout for the finished command |
| rsp_rdata | output | DATA_W | Data from the last read |
| eep_cs | output | 1 | Chip select to the device |
| eep_sk | output | 1 | Serial clock to the device |
| eep_mosi | output | 1 | Serial data to the device |
| eep_miso | input | 1 | Serial data / ready status from the device |

## Verification
The assertions watch the pin-level rules on every cycle. They cover the serial clock only running under chip select, data holding steady across rising edges and high phases, chip select rising with the clock low, the done pulse lasting one cycle, idle meaning an inactive bus, and no acceptance during power-up. Only the bench scenarios can show the rest, because it depends on what a device model returns and on the command sequence. That covers the bit content of each frame for every operation, the exact phase lengths and chip-select gaps, read data assembly past the dummy bit, the presence or absence of a poll, timeout reporting, and commands dropped while busy.

// File: rtl/mw_ctl_pkg.sv
package mw_ctl_pkg;
  typedef enum logic [2:0] {
    OP_READ  = 3'd0,
    OP_WRITE = 3'd1,
    OP_ERASE = 3'd2,
    OP_WREN  = 3'd3,
    OP_WRDIS = 3'd4,
    OP_ERALL = 3'd5,
    OP_WRALL = 3'd6,
    OP_RSVD  = 3'd7
  } op_e;

  typedef enum logic [2:0] {
    ST_PWR,
    ST_IDLE,
    ST_LO,
    ST_HI,
    ST_GAP,
    ST_POLL
  } st_e;
endpackage

// File: rtl/mw_tick_gen.sv
module mw_tick_gen #(
  parameter int HALF_CYC = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic clr,
  output logic tick
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == CW'(HALF_CYC - 1));

  always_ff @(posedge clk) begin
    if (rst || !run || clr || tick) cnt <= '0;
    else                            cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/mw_countdown.sv
module mw_countdown #(
  parameter int W    = 8,
  parameter int INIT = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         en,
  output logic         zero
);
  logic [W-1:0] cnt;

  assign zero = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst)                cnt <= W'(INIT);
    else if (load)          cnt <= load_val;
    else if (en && !zero)   cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/mw_frame_enc.sv
module mw_frame_enc
  import mw_ctl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int SLOT_W = 5,
  localparam int HDR_W   = 3 + ADDR_W,
  localparam int FRAME_W = HDR_W + DATA_W
) (
  input  op_e                op,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [FRAME_W-1:0] frame,
  output logic [SLOT_W-1:0]  nslots,
  output logic               is_read,
  output logic               is_wr
);
  localparam int RD_SLOTS = HDR_W + DATA_W + 1;

  logic [1:0]        opc;
  logic [ADDR_W-1:0] afld;
  logic              has_data;

  always_comb begin
    opc      = 2'b00;
    afld     = {2'b00, {(ADDR_W-2){1'b0}}};
    has_data = 1'b0;
    is_read  = 1'b0;
    is_wr    = 1'b0;
    case (op)
      OP_READ:  begin opc = 2'b10; afld = addr; is_read = 1'b1; end
      OP_WRITE: begin opc = 2'b01; afld = addr; has_data = 1'b1; is_wr = 1'b1; end
      OP_ERASE: begin opc = 2'b11; afld = addr; is_wr = 1'b1; end
      OP_WREN:  afld = {2'b11, {(ADDR_W-2){1'b0}}};
      OP_ERALL: begin afld = {2'b10, {(ADDR_W-2){1'b0}}}; is_wr = 1'b1; end
      OP_WRALL: begin afld = {2'b01, {(ADDR_W-2){1'b0}}}; has_data = 1'b1; is_wr = 1'b1; end
      default:  afld = {2'b00, {(ADDR_W-2){1'b0}}};
    endcase
    frame = {1'b1, opc, afld, (has_data ? wdata : {DATA_W{1'b0}})};
    if (is_read)       nslots = SLOT_W'(RD_SLOTS);
    else if (has_data) nslots = SLOT_W'(FRAME_W);
    else               nslots = SLOT_W'(HDR_W);
  end
endmodule

// File: rtl/mw_host_ctl.sv
module mw_host_ctl
  import mw_ctl_pkg::*;
#(
  parameter int CLK_HZ       = 100_000_000,
  parameter int SK_HZ        = 2_000_000,
  parameter int ADDR_W       = 8,
  parameter int DATA_W       = 16,
  parameter int PWRUP_CYC    = 100_000,
  parameter int BUSY_TMO_CYC = 500_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              cmd_ready,
  output logic              rsp_done,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              eep_cs,
  output logic              eep_sk,
  output logic              eep_mosi,
  input  logic              eep_miso
);
  localparam int HALF_CYC = (CLK_HZ + 2*SK_HZ - 1) / (2*SK_HZ);
  localparam int HDR_W    = 3 + ADDR_W;
  localparam int FRAME_W  = HDR_W + DATA_W;
  localparam int RD_SLOTS = HDR_W + DATA_W + 1;
  localparam int SLOT_W   = $clog2(RD_SLOTS + 1);
  localparam int PW_W     = $clog2(PWRUP_CYC + 1);
  localparam int TMO_W    = $clog2(BUSY_TMO_CYC + 1);

  st_e                st;
  logic [FRAME_W-1:0] sh;
  logic [SLOT_W-1:0]  slot, nsl;
  logic               rd_op, wr_op, poll_pend, err_q;
  logic [DATA_W-1:0]  rx;

  logic [FRAME_W-1:0] enc_frame;
  logic [SLOT_W-1:0]  enc_nsl;
  logic               enc_rd, enc_wr;
  logic               tick, tick_run, tick_clr;
  logic               pwr_zero, tmo_zero, tmo_load;

  assign cmd_ready = (st == ST_IDLE);
  assign tick_run  = (st == ST_LO) || (st == ST_HI) || (st == ST_GAP) || (st == ST_POLL);
  assign tick_clr  = (st == ST_POLL) && tmo_zero && !(tick && eep_miso);
  assign tmo_load  = (st == ST_GAP) && tick && poll_pend;

  mw_frame_enc #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SLOT_W(SLOT_W)) enc_i (
    .op(op_e'(cmd_op)), .addr(cmd_addr), .wdata(cmd_wdata),
    .frame(enc_frame), .nslots(enc_nsl), .is_read(enc_rd), .is_wr(enc_wr)
  );

  mw_tick_gen #(.HALF_CYC(HALF_CYC)) tick_i (
    .clk(clk), .rst(rst), .run(tick_run), .clr(tick_clr), .tick(tick)
  );

  mw_countdown #(.W(PW_W), .INIT(PWRUP_CYC)) pwr_i (
    .clk(clk), .rst(rst), .load(1'b0), .load_val('0),
    .en(st == ST_PWR), .zero(pwr_zero)
  );

  mw_countdown #(.W(TMO_W), .INIT(0)) tmo_i (
    .clk(clk), .rst(rst), .load(tmo_load), .load_val(TMO_W'(BUSY_TMO_CYC)),
    .en(st == ST_POLL), .zero(tmo_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_PWR;
      sh        <= '0;
      slot      <= '0;
      nsl       <= '0;
      rd_op     <= 1'b0;
      wr_op     <= 1'b0;
      poll_pend <= 1'b0;
      err_q     <= 1'b0;
      rx        <= '0;
      eep_cs    <= 1'b0;
      eep_sk    <= 1'b0;
      eep_mosi  <= 1'b0;
      rsp_done  <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_done <= 1'b0;
      case (st)
        ST_PWR: if (pwr_zero) st <= ST_IDLE;
        ST_IDLE: if (cmd_valid) begin
          sh        <= enc_frame;
          nsl       <= enc_nsl;
          rd_op     <= enc_rd;
          wr_op     <= enc_wr;
          slot      <= SLOT_W'(1);
          err_q     <= 1'b0;
          poll_pend <= 1'b0;
          eep_cs    <= 1'b1;
          eep_mosi  <= enc_frame[FRAME_W-1];
          st        <= ST_LO;
        end
        ST_LO: if (tick) begin
          if (rd_op && (slot > SLOT_W'(HDR_W))) rx <= {rx[DATA_W-2:0], eep_miso};
          eep_sk <= 1'b1;
          st     <= ST_HI;
        end
        ST_HI: if (tick) begin
          eep_sk <= 1'b0;
          if (slot == nsl) begin
            eep_cs    <= 1'b0;
            eep_mosi  <= 1'b0;
            poll_pend <= wr_op;
            st        <= ST_GAP;
          end else begin
            slot     <= slot + 1'b1;
            sh       <= {sh[FRAME_W-2:0], 1'b0};
            eep_mosi <= sh[FRAME_W-2];
            st       <= ST_LO;
          end
        end
        ST_GAP: if (tick) begin
          if (poll_pend) begin
            poll_pend <= 1'b0;
            eep_cs    <= 1'b1;
            st        <= ST_POLL;
          end else begin
            rsp_done <= 1'b1;
            rsp_err  <= err_q;
            if (rd_op) rsp_rdata <= rx;
            st <= ST_IDLE;
          end
        end
        ST_POLL: begin
          if (tick && eep_miso) begin
            eep_cs <= 1'b0;
            st     <= ST_GAP;
          end else if (tmo_zero) begin
            eep_cs <= 1'b0;
            err_q  <= 1'b1;
            st     <= ST_GAP;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mw_host_chk.sv
module mw_host_chk #(
  parameter int PWRUP_CYC = 100_000
) (
  input logic clk,
  input logic rst,
  input logic cmd_ready,
  input logic rsp_done,
  input logic eep_cs,
  input logic eep_sk,
  input logic eep_mosi
);
  localparam int AW = $clog2(PWRUP_CYC + 1) + 1;

  logic [AW-1:0] age;

  always_ff @(posedge clk) begin
    if (rst)                         age <= '0;
    else if (age < AW'(PWRUP_CYC))   age <= age + 1'b1;
  end

  p_no_early_ready_r1: assert property (@(posedge clk) disable iff (rst)
    (age < AW'(PWRUP_CYC)) |-> !cmd_ready);

  p_sk_under_cs_r4: assert property (@(posedge clk) disable iff (rst)
    eep_sk |-> eep_cs);

  p_mosi_setup_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(eep_sk) |-> $stable(eep_mosi));

  p_mosi_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (eep_sk && $past(eep_sk)) |-> $stable(eep_mosi));

  p_cs_rise_sk_low_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(eep_cs) |-> !eep_sk);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);

  p_idle_bus_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    cmd_ready |-> (!eep_cs && !eep_sk));
endmodule

bind mw_host_ctl mw_host_chk #(.PWRUP_CYC(PWRUP_CYC)) chk_i (
  .clk(clk), .rst(rst), .cmd_ready(cmd_ready), .rsp_done(rsp_done),
  .eep_cs(eep_cs), .eep_sk(eep_sk), .eep_mosi(eep_mosi)
);

// File: tb/mw_host_ctl_tb_top.sv
module mw_host_ctl_tb_top;
  localparam int HALF  = 25;
  localparam int PWRUP = 400;
  localparam int TMO   = 3000;
  localparam int BUSY  = 600;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = '0;
  logic [7:0]  cmd_addr = '0;
  logic [15:0] cmd_wdata = '0;
  logic        cmd_ready, rsp_done, rsp_err;
  logic [15:0] rsp_rdata;
  logic        eep_cs, eep_sk, eep_mosi, eep_miso;

  always #5 clk = ~clk;

  mw_host_ctl #(
    .CLK_HZ(100_000_000), .SK_HZ(2_000_000), .ADDR_W(8), .DATA_W(16),
    .PWRUP_CYC(PWRUP), .BUSY_TMO_CYC(TMO)
  ) dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_ready(cmd_ready),
    .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .eep_cs(eep_cs), .eep_sk(eep_sk), .eep_mosi(eep_mosi), .eep_miso(eep_miso)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit finished = 1'b0;

  typedef struct { int n; logic [63:0] v; } frm_t;
  frm_t exp_q[$];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mem_val(input logic [7:0] a);
    return {a, ~a} ^ 16'h1234;
  endfunction

  // ---------------- device model and pin monitor ----------------
  logic        cs_q = 1'b0, sk_q = 1'b0, mosi_q = 1'b0;
  logic [63:0] fbits;
  int          fn = 0, hi_len = 0, lo_len = 0, cs_low = 0, tbad = 0, cs_rises = 0;
  int          busy_left = 0, rd_pos = 0;
  bit          reading = 1'b0, stuck_busy = 1'b0;
  logic        miso_r = 1'b0;
  logic [15:0] rd_word;

  assign eep_miso = reading ? miso_r : (busy_left == 0 && !stuck_busy);

  always @(posedge clk) begin
    cyc++;
    if (busy_left > 0) busy_left--;
    if (rst) begin
      fn = 0; tbad = 0; hi_len = 0; lo_len = 0; cs_low = 0; reading = 1'b0;
    end else begin
      if (eep_cs && !cs_q) begin
        cs_rises++;
        chk(cs_low >= HALF, "R6 chip-select low gap", cs_low, HALF);
        fn = 0; fbits = '0; reading = 1'b0; lo_len = 0;
      end
      if (!eep_cs) cs_low++; else cs_low = 0;
      if (eep_sk && !sk_q) begin
        if (lo_len != HALF) tbad++;
        lo_len = 0;
        fbits = {fbits[62:0], eep_mosi};
        fn++;
        if (fn == 11 && fbits[10:8] == 3'b110) begin
          reading = 1'b1; rd_word = mem_val(fbits[7:0]); rd_pos = 16; miso_r <= 1'b0;
        end else if (reading && rd_pos > 0) begin
          miso_r <= rd_word[rd_pos-1]; rd_pos--;
        end
      end
      if (eep_sk) begin
        hi_len++;
        if (sk_q && eep_mosi != mosi_q) tbad++;
      end else begin
        if (sk_q) begin
          if (hi_len != HALF) tbad++;
          hi_len = 0;
        end
        if (eep_cs) lo_len++;
      end
      if (!eep_cs && cs_q && fn > 0) begin
        logic [10:0] hdr;
        bit wt;
        frm_t e;
        hdr = 11'(fbits >> (fn - 11));
        wt = (hdr[9:8] == 2'b01) || (hdr[9:8] == 2'b11) ||
             (hdr[9:8] == 2'b00 && (hdr[7:6] == 2'b10 || hdr[7:6] == 2'b01));
        if (wt) busy_left = BUSY;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R9 unexpected frame", 64'(fn), 0);
        end else begin
          e = exp_q.pop_front();
          chk(fn == e.n, "R2 frame length", 64'(fn), 64'(e.n));
          chk(fbits == e.v, "R2/R3 frame bits", fbits, e.v);
          chk(tbad == 0, "R4 clock phase timing", 64'(tbad), 0);
        end
        tbad = 0; fn = 0; reading = 1'b0;
      end
    end
    cs_q = eep_cs; sk_q = eep_sk; mosi_q = eep_mosi;
  end

  // ---------------- driver ----------------
  function automatic frm_t exp_frame(input logic [2:0] op, input logic [7:0] a, input logic [15:0] d);
    frm_t f;
    logic [10:0] h;
    case (op)
      3'd0: h = {3'b110, a};
      3'd1: h = {3'b101, a};
      3'd2: h = {3'b111, a};
      3'd3: h = {3'b100, 8'hC0};
      3'd5: h = {3'b100, 8'h80};
      3'd6: h = {3'b100, 8'h40};
      default: h = {3'b100, 8'h00};
    endcase
    if (op == 3'd0)                   begin f.n = 28; f.v = 64'(h) << 17; end
    else if (op == 3'd1 || op == 3'd6) begin f.n = 27; f.v = (64'(h) << 16) | 64'(d); end
    else                               begin f.n = 11; f.v = 64'(h); end
    return f;
  endfunction

  task automatic run_cmd(input logic [2:0] op, input logic [7:0] a, input logic [15:0] d,
                         input bit exp_err, input string tag, output int dur);
    int rises0, t0;
    while (!cmd_ready) @(negedge clk);
    exp_q.push_back(exp_frame(op, a, d));
    rises0 = cs_rises;
    cmd_op = op; cmd_addr = a; cmd_wdata = d; cmd_valid = 1'b1;
    t0 = cyc;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!rsp_done) @(negedge clk);
    dur = cyc - t0;
    chk(rsp_err == exp_err, {tag, " error flag"}, 64'(rsp_err), 64'(exp_err));
    if (op == 3'd1 || op == 3'd2 || op == 3'd5 || op == 3'd6)
      chk(cs_rises - rises0 == 2, "R7 poll after programming op", 64'(cs_rises - rises0), 2);
    else
      chk(cs_rises - rises0 == 1, "R10 no poll", 64'(cs_rises - rises0), 1);
    @(negedge clk);
    chk(!rsp_done, "R9 done single pulse", 64'(rsp_done), 0);
  endtask

  initial begin
    int dur;
    repeat (5) @(negedge clk);
    chk({cmd_ready, eep_cs, eep_sk, eep_mosi, rsp_done, rsp_err} == 6'b0, "R1 reset outputs",
        {cmd_ready, eep_cs, eep_sk, eep_mosi, rsp_done, rsp_err}, 0);
    chk(rsp_rdata == 16'h0, "R1 reset rdata", rsp_rdata, 0);
    rst = 1'b0;
    cmd_valid = 1'b1; cmd_op = 3'd1;
    begin
      bit early = 1'b0;
      for (int k = 0; k < PWRUP - 5; k++) begin
        @(negedge clk);
        if (cmd_ready || eep_cs) early = 1'b1;
      end
      chk(!early, "R1 held off during power-up", 64'(early), 0);
    end
    cmd_valid = 1'b0;
    repeat (10) @(negedge clk);
    chk(cmd_ready, "R1 ready after power-up", 64'(cmd_ready), 1);
    chk(cs_rises == 0, "R1 no frame during power-up", 64'(cs_rises), 0);

    run_cmd(3'd3, 8'h00, 16'h0, 1'b0, "R3 write-enable", dur);
    run_cmd(3'd1, 8'h3C, 16'hBEEF, 1'b0, "R2 write", dur);
    chk(dur > BUSY, "R7 write waits for ready", 64'(dur), BUSY);
    run_cmd(3'd0, 8'h3C, 16'h0, 1'b0, "R5 read", dur);
    chk(rsp_rdata == mem_val(8'h3C), "R5 read data 3C", rsp_rdata, mem_val(8'h3C));
    run_cmd(3'd0, 8'hFF, 16'h0, 1'b0, "R5 read", dur);
    chk(rsp_rdata == mem_val(8'hFF), "R5 read data FF", rsp_rdata, mem_val(8'hFF));
    run_cmd(3'd2, 8'h81, 16'h0, 1'b0, "R2 erase", dur);
    run_cmd(3'd5, 8'h55, 16'h0, 1'b0, "R3 erase-all", dur);
    run_cmd(3'd6, 8'hAA, 16'h1234, 1'b0, "R3 write-all", dur);
    run_cmd(3'd4, 8'h7E, 16'h0, 1'b0, "R3 write-disable", dur);

    // R9: command presented while busy must be dropped
    fork
      run_cmd(3'd0, 8'h00, 16'h0, 1'b0, "R5 read", dur);
      begin
        repeat (200) @(negedge clk);
        chk(!cmd_ready, "R9 not ready while busy", 64'(cmd_ready), 0);
        cmd_valid = 1'b1; cmd_op = 3'd1;
        repeat (3) @(negedge clk);
        cmd_valid = 1'b0;
      end
    join
    chk(rsp_rdata == mem_val(8'h00), "R5 read data 00", rsp_rdata, mem_val(8'h00));
    repeat (200) @(negedge clk);
    chk(exp_q.size() == 0 && !eep_cs, "R9 busy command ignored", 64'(exp_q.size()), 0);

    // R8: device never becomes ready
    stuck_busy = 1'b1;
    run_cmd(3'd1, 8'h10, 16'h0F0F, 1'b1, "R8 timeout", dur);
    chk(dur >= TMO && !eep_cs, "R8 timeout duration", 64'(dur), TMO);
    stuck_busy = 1'b0;
    run_cmd(3'd3, 8'h00, 16'h0, 1'b0, "R8 error cleared next op", dur);

    chk(exp_q.size() == 0, "R2 all frames seen", 64'(exp_q.size()), 0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired act=1 exp=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule